// File: doc/BRIEF.md
# Programmable Per-Component Range Clipper

This block is one pipeline stage in a video output path. It takes a 24-bit pixel made of three 8-bit components and clamps each component into its own programmable window. A component above its upper limit leaves as that limit. A component below its lower limit leaves as that lower limit. Any other value passes through unchanged. The data-enable, horizontal-sync and vertical-sync flags travel next to the pixel and arrive with the same one-clock delay.

While reset is held, the block loads default limits. The `ycbcrMode` input chooses between two sets: video-legal limits for luma/chroma data, or near-full-scale limits for RGB data. After reset, software can replace the upper-limit word or the lower-limit word through a one-cycle write port. A `fullRange` input turns clamping off entirely. Pixels in the blanking interval (data enable low) are never clamped.

Top module: `rangeClipper`

## Requirements
- R1: While `rstN` is low with `ycbcrMode`=1, the block loads an upper-limit word of {0xF0, 0xEB, 0xF0} and a lower-limit word of {0x10, 0x10, 0x10}. Each word is laid out as bits [23:16] red/Cr, [15:8] green/Y, [7:0] blue/Cb.
- R2: While `rstN` is low with `ycbcrMode`=0, the block loads 0xFE as the upper limit and 0x01 as the lower limit for every component.
- R3: When data enable is high and `fullRange` is low, a component larger than its upper limit is output as the upper limit.
- R4: Under the same conditions, a component smaller than its lower limit is output as the lower limit.
- R5: A component that lies between its limits, inclusive, is output unchanged.
- R6: Each component is compared only against its own limit pair. Components that share a pixel are clamped independently.
- R7: When `fullRange` is high, every component passes unchanged.
- R8: When data enable is low, the pixel passes unchanged, whatever the limits are.
- R9: `pixOut`, `deOut`, `hsOut` and `vsOut` show the values that `pixIn`, `deIn`, `hsIn` and `vsIn` had one clock earlier.
- R10: A write with `wrEn`=1 stores `wrData` as the upper-limit word when `wrSel`=0, or as the lower-limit word when `wrSel`=1. The new word governs the pixel sampled on the next clock. A pixel sampled in the same clock as the write still uses the old limits.
- R11: Changing `ycbcrMode` after reset leaves the limits untouched until the next reset.
- R12: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset; loads the default limits |
| ycbcrMode | input | 1 | 1 selects YCbCr default limits, 0 selects RGB default limits |
| fullRange | input | 1 | 1 disables clamping |
| wrEn | input | 1 | Limit write strobe |
| wrSel | input | 1 | 0 writes the upper-limit word, 1 writes the lower-limit word |
| wrData | input | 24 | Limit word being written |
| pixIn | input | 24 | Input pixel |
| deIn | input | 1 | Input data enable |
| hsIn | input | 1 | Input horizontal sync |
| vsIn | input | 1 | Input vertical sync |
| pixOut | output | 24 | Clamped pixel |
| deOut | output | 1 | Delayed data enable |
| hsOut | output | 1 | Delayed horizontal sync |
| vsOut | output | 1 | Delayed vertical sync |

## Verification
The bench builds the block with its default widths: three 8-bit components in a 24-bit pixel. At these widths, every clamp value and default limit can be written as an exact byte. Driving pixels of all zeros and all ones reveals the current lower and upper limit words at the output, so the stored limits can be observed without reading internal state. This makes it possible to check both default sets, mode changes made after reset, and the exact clock at which a written limit starts to apply.

// File: rtl/clipPkg.sv
package clipPkg;
  localparam int COMP_W   = 8;
  localparam int NUM_COMP = 3;
  localparam int PIX_W    = COMP_W * NUM_COMP;

  // default limits per colour space
  localparam logic [COMP_W-1:0] YC_LUMA_MAX   = 8'hEB;
  localparam logic [COMP_W-1:0] YC_CHROMA_MAX = 8'hF0;
  localparam logic [COMP_W-1:0] YC_MIN        = 8'h10;
  localparam logic [COMP_W-1:0] RGB_MAX       = 8'hFE;
  localparam logic [COMP_W-1:0] RGB_MIN       = 8'h01;

  // index of the luma / green lane inside a pixel word
  localparam int LUMA_LANE = 1;

  typedef struct packed {
    logic [PIX_W-1:0] maxLim;
    logic [PIX_W-1:0] minLim;
    logic             clampEn;
  } limitBundle_t;

  function automatic logic [PIX_W-1:0] defaultMax(input logic ycMode);
    logic [PIX_W-1:0] w;
    for (int i = 0; i < NUM_COMP; i++) begin
      if (!ycMode)             w[i*COMP_W +: COMP_W] = RGB_MAX;
      else if (i == LUMA_LANE) w[i*COMP_W +: COMP_W] = YC_LUMA_MAX;
      else                     w[i*COMP_W +: COMP_W] = YC_CHROMA_MAX;
    end
    return w;
  endfunction

  function automatic logic [PIX_W-1:0] defaultMin(input logic ycMode);
    logic [PIX_W-1:0] w;
    for (int i = 0; i < NUM_COMP; i++)
      w[i*COMP_W +: COMP_W] = ycMode ? YC_MIN : RGB_MIN;
    return w;
  endfunction
endpackage

// File: rtl/clipLimitCtrl.sv
module clipLimitCtrl
  import clipPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ycbcrMode,
  input  logic             fullRange,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [PIX_W-1:0] wrData,
  output limitBundle_t     limits
);
  logic [PIX_W-1:0] maxReg;
  logic [PIX_W-1:0] minReg;

  // mode only matters while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxReg <= defaultMax(ycbcrMode);
      minReg <= defaultMin(ycbcrMode);
    end else if (wrEn) begin
      if (wrSel) minReg <= wrData;
      else       maxReg <= wrData;
    end
  end

  always_comb begin
    limits.maxLim  = maxReg;
    limits.minLim  = minReg;
    limits.clampEn = ~fullRange;
  end

  p_limits_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(maxReg) && $stable(minReg)));

  p_write_max_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (maxReg == $past(wrData) && $stable(minReg)));

  p_write_min_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> (minReg == $past(wrData) && $stable(maxReg)));
endmodule

// File: rtl/clipDatapath.sv
module clipDatapath
  import clipPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  limitBundle_t     limits,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             deIn,
  input  logic             hsIn,
  input  logic             vsIn,
  output logic [PIX_W-1:0] pixOut,
  output logic             deOut,
  output logic             hsOut,
  output logic             vsOut
);
  logic [PIX_W-1:0] clampedPix;
  logic             pastValid;

  for (genvar g = 0; g < NUM_COMP; g++) begin : gLane
    logic [COMP_W-1:0] inC, hiC, loC, outC;
    assign inC = pixIn[g*COMP_W +: COMP_W];
    assign hiC = limits.maxLim[g*COMP_W +: COMP_W];
    assign loC = limits.minLim[g*COMP_W +: COMP_W];

    always_comb begin
      if (!(deIn && limits.clampEn)) outC = inC;
      else if (inC > hiC)            outC = hiC;
      else if (inC < loC)            outC = loC;
      else                           outC = inC;
    end
    assign clampedPix[g*COMP_W +: COMP_W] = outC;

    p_upper_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && deOut && $past(limits.clampEn) &&
       ($past(limits.minLim[g*COMP_W +: COMP_W]) <= $past(limits.maxLim[g*COMP_W +: COMP_W])))
      |-> (pixOut[g*COMP_W +: COMP_W] <= $past(limits.maxLim[g*COMP_W +: COMP_W])));

    p_lower_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && deOut && $past(limits.clampEn) &&
       ($past(limits.minLim[g*COMP_W +: COMP_W]) <= $past(limits.maxLim[g*COMP_W +: COMP_W])))
      |-> (pixOut[g*COMP_W +: COMP_W] >= $past(limits.minLim[g*COMP_W +: COMP_W])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut    <= '0;
      deOut     <= 1'b0;
      hsOut     <= 1'b0;
      vsOut     <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      pixOut    <= clampedPix;
      deOut     <= deIn;
      hsOut     <= hsIn;
      vsOut     <= vsIn;
      pastValid <= 1'b1;
    end
  end

  p_flag_delay_r9: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (deOut == $past(deIn) && hsOut == $past(hsIn) && vsOut == $past(vsIn)));

  p_blank_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !deOut) |-> (pixOut == $past(pixIn)));

  p_full_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(limits.clampEn)) |-> (pixOut == $past(pixIn)));
endmodule

// File: rtl/rangeClipper.sv
module rangeClipper
  import clipPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ycbcrMode,
  input  logic             fullRange,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [PIX_W-1:0] wrData,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             deIn,
  input  logic             hsIn,
  input  logic             vsIn,
  output logic [PIX_W-1:0] pixOut,
  output logic             deOut,
  output logic             hsOut,
  output logic             vsOut
);
  limitBundle_t limits;

  clipLimitCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ycbcrMode (ycbcrMode),
    .fullRange (fullRange),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .limits    (limits)
  );

  clipDatapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .limits (limits),
    .pixIn  (pixIn),
    .deIn   (deIn),
    .hsIn   (hsIn),
    .vsIn   (vsIn),
    .pixOut (pixOut),
    .deOut  (deOut),
    .hsOut  (hsOut),
    .vsOut  (vsOut)
  );

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rstN |=> (pixOut == '0 && !deOut && !hsOut && !vsOut));
endmodule

// File: tb/sim_rangeClipper.sv
module sim_rangeClipper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ycbcrMode = 1'b1;
  logic        fullRange = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [23:0] wrData = '0;
  logic [23:0] pixIn = '0;
  logic        deIn = 1'b0, hsIn = 1'b0, vsIn = 1'b0;
  logic [23:0] pixOut;
  logic        deOut, hsOut, vsOut;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rangeClipper u0 (.*);

  task automatic check(input string req, input logic [26:0] act, input logic [26:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller sits just after a negedge; drive, then sample one negedge later
  task automatic pix(input string req, input logic [23:0] p, input logic de,
                     input logic hs, input logic vs, input logic [23:0] exp);
    pixIn = p; deIn = de; hsIn = hs; vsIn = vs;
    @(negedge clk);
    check(req, {pixOut, deOut, hsOut, vsOut}, {exp, de, hs, vs});
  endtask

  task automatic doReset(input logic mode);
    ycbcrMode = mode; rstN = 1'b0;
    pixIn = 24'hA5A5A5; deIn = 1'b1; hsIn = 1'b1; vsIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", {pixOut, deOut, hsOut, vsOut}, 27'd0);
    rstN = 1'b1; deIn = 1'b0; hsIn = 1'b0; vsIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testYcDefaults;
    doReset(1'b1);
    pix("R1", 24'hFFFFFF, 1, 0, 0, 24'hF0EBF0);
    pix("R1", 24'h000000, 1, 0, 0, 24'h101010);
  endtask

  task automatic testClampLanes;
    pix("R3", 24'hF5EC00, 1, 0, 0, 24'hF0EB10);
    pix("R4", 24'h0F0001, 1, 0, 0, 24'h101010);
    pix("R5", 24'h80EB10, 1, 0, 0, 24'h80EB10);
    pix("R6", 24'hFF0580, 1, 0, 0, 24'hF01080);
    pix("R6", 24'h02FFF1, 1, 0, 0, 24'h10EBF0);
  endtask

  task automatic testPassModes;
    fullRange = 1'b1;
    pix("R7", 24'hFF00FF, 1, 0, 0, 24'hFF00FF);
    fullRange = 1'b0;
    pix("R8", 24'hFF00FF, 0, 1, 0, 24'hFF00FF);
    pix("R9", 24'h123456, 0, 0, 1, 24'h123456);
    pix("R9", 24'h808080, 1, 1, 1, 24'h808080);
  endtask

  task automatic testWrite;
    // write upper word; the pixel in the same clock still sees the old word
    wrEn = 1'b1; wrSel = 1'b0; wrData = 24'hC0A0B0;
    pix("R10", 24'hFFFFFF, 1, 0, 0, 24'hF0EBF0);
    wrEn = 1'b0;
    pix("R10", 24'hFFFFFF, 1, 0, 0, 24'hC0A0B0);
    pix("R10", 24'h000000, 1, 0, 0, 24'h101010);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 24'h203040;
    pix("R10", 24'h000000, 1, 0, 0, 24'h101010);
    wrEn = 1'b0;
    pix("R10", 24'h000000, 1, 0, 0, 24'h203040);
    pix("R10", 24'hFFFFFF, 1, 0, 0, 24'hC0A0B0);
  endtask

  task automatic testModeAfterReset;
    doReset(1'b1);
    ycbcrMode = 1'b0;
    @(negedge clk);
    pix("R11", 24'hFFFFFF, 1, 0, 0, 24'hF0EBF0);
    pix("R11", 24'h000000, 1, 0, 0, 24'h101010);
    doReset(1'b0);
    pix("R2", 24'hFFFFFF, 1, 0, 0, 24'hFEFEFE);
    pix("R2", 24'h000000, 1, 0, 0, 24'h010101);
    ycbcrMode = 1'b1;
    pix("R11", 24'hFF00FF, 1, 0, 0, 24'hFE01FE);
  endtask

  initial begin
    @(negedge clk);
    testYcDefaults;
    testClampLanes;
    testPassModes;
    testWrite;
    testModeAfterReset;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule